// File: doc/BRIEF.md
# Exception and Interrupt Entry Sequencer

This block decides, on each qualified event, whether the processor enters a synchronous exception handler, enters an external interrupt handler, or does nothing. It then performs every state change that entry needs in a single clock edge. The changes are: save the status word, program counter and stack pointer into their shadow copies; raise the block, privilege and bank bits; rewind the saved PC when the faulting instruction sat in a branch delay slot; record the event code; and load the new PC.

The core presents its current status word, PC, R15, vector base and delay-slot flags together with an event strobe. It also presents a pending exception code, an interrupt request, and the vector answered by the interrupt controller. The sequencer drives the current mask level to that controller combinationally. One cycle after the strobe, the updated registers appear on the outputs, together with single-cycle pulses. These pulses mark the take, the clearing of the delay-slot flags and the clearing of the halted flag. While the block bit is set, exceptions escalate to reset and interrupts are held off. The one exception to this is a core that is halted waiting for an interrupt.

Top module: `exsq_entry`

## Requirements
- R1: After reset, pc_o reads 0xA0000000, sr_o reads 0x500000F0 (privilege bit 30 and block bit 28 set, mask field bits 7:4 at 0xF), every other register output reads 0, and all pulses are low.
- R2: When an exception and an interrupt are both pending on the same event, the exception is taken: expevt_o gets the exception code, intevt_o keeps its old value, and the PC follows the exception rules.
- R3: With the block bit sr_in[28] set, a pending exception whose code is not 0x1E0 is taken as code 0x000. Code 0x1E0 keeps its own code and is handled normally.
- R4: With sr_in[28] set, an interrupt is not taken unless halted is high, and no register output changes. Any entry taken while sr_in[28] is set pulses halt_clr_o.
- R5: ic_mask equals sr_in[7:4] at all times. An interrupt request with ic_vld low is not taken, and the outputs hold.
- R6: On any entry, ssr_o takes sr_in, spc_o takes pc_in, sgr_o takes r15_in, and sr_o is sr_in with bits 28 (block), 29 (bank) and 30 (privilege) set.
- R7: If ds_flag or ds_cond_flag is high at entry, spc_o is pc_in minus 2 and ds_clr_o pulses.
- R8: Exception codes 0x000, 0x020 and 0x140 clear sr_o[15], force sr_o[7:4] to 0xF and load pc_o with 0xA0000000.
- R9: Exception codes 0x040 and 0x060 load pc_o with vbr_in + 0x400.
- R10: Every other exception code loads pc_o with vbr_in + 0x100. Code 0x160 additionally adds 2 to the saved PC.
- R11: A taken interrupt loads intevt_o with ic_vec, loads pc_o with vbr_in + 0x600, and leaves expevt_o unchanged.
- R12: Outputs change only at the clock edge that samples evt_en high. taken_o is high for exactly that following cycle. Without evt_en, pending requests have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| evt_en | input | 1 | Event strobe qualifying the inputs below |
| exc_pend | input | 1 | A synchronous exception is pending |
| exc_code | input | 12 | Code of the pending exception |
| irq_req | input | 1 | External interrupt request |
| halted | input | 1 | Core is halted awaiting an interrupt |
| ic_mask | output | 4 | Current mask level, sr_in[7:4], to the interrupt controller |
| ic_vld | input | 1 | Interrupt controller has an unmasked vector |
| ic_vec | input | 12 | Vector from the interrupt controller |
| sr_in | input | 32 | Current status word |
| pc_in | input | 32 | Current program counter |
| r15_in | input | 32 | Current stack pointer |
| vbr_in | input | 32 | Vector base |
| ds_flag | input | 1 | Instruction is in an unconditional delay slot |
| ds_cond_flag | input | 1 | Instruction is in a conditional delay slot |
| sr_o | output | 32 | Updated status word |
| ssr_o | output | 32 | Saved status word |
| spc_o | output | 32 | Saved program counter |
| sgr_o | output | 32 | Saved stack pointer |
| pc_o | output | 32 | Handler program counter |
| expevt_o | output | 12 | Last exception code |
| intevt_o | output | 12 | Last interrupt vector |
| taken_o | output | 1 | Entry performed at the last edge |
| ds_clr_o | output | 1 | Delay-slot flags must be cleared |
| halt_clr_o | output | 1 | Halted flag must be cleared |

## Verification
The bench builds the block with its defaults. These are a 32-bit data path, 12-bit event codes, handler offsets 0x100, 0x400 and 0x600, and a reset vector of 0xA0000000. The three offsets and the reset vector are all distinct, so every handler class is told apart by pc_o alone. A vector base of 0x8C000000 places each handler in a separate, recognisable range. With these values, one run reaches every code class, both delay-slot kinds, block-bit escalation and the halted override.

// File: rtl/exsq_pkg.sv
package exsq_pkg;
  localparam int SR_W     = 32;
  localparam int SR_BL    = 28;
  localparam int SR_RB    = 29;
  localparam int SR_MD    = 30;
  localparam int SR_FD    = 15;
  localparam int IMASK_LO = 4;
  localparam int IMASK_W  = 4;

  typedef enum logic [1:0] {
    ENT_NONE = 2'd0,
    ENT_EXC  = 2'd1,
    ENT_IRQ  = 2'd2
  } entry_kind_e;

  typedef enum logic [1:0] {
    DST_GENERAL = 2'd0,
    DST_TLB     = 2'd1,
    DST_RESET   = 2'd2
  } dest_class_e;
endpackage

// File: rtl/exsq_arbiter.sv
module exsq_arbiter
  import exsq_pkg::*;
#(
  parameter int CODE_W = 12
) (
  input  logic              exc_pend,
  input  logic [CODE_W-1:0] exc_code,
  input  logic              irq_req,
  input  logic              halted,
  input  logic              blocked,
  input  logic              ic_vld,
  output entry_kind_e       kind,
  output logic [CODE_W-1:0] code,
  output logic              wake
);
  localparam logic [CODE_W-1:0] C_KEEP = CODE_W'(12'h1E0);

  always_comb begin
    kind = ENT_NONE;
    code = exc_code;
    wake = 1'b0;
    if (exc_pend) begin
      kind = ENT_EXC;
      wake = blocked;
      if (blocked && (exc_code != C_KEEP)) code = '0;
    end else if (irq_req && ic_vld && (!blocked || halted)) begin
      kind = ENT_IRQ;
      wake = blocked;
    end
  end
endmodule

// File: rtl/exsq_target.sv
module exsq_target
  import exsq_pkg::*;
#(
  parameter int              XLEN     = 32,
  parameter int              CODE_W   = 12,
  parameter int unsigned     OFS_GEN  = 32'h100,
  parameter int unsigned     OFS_TLB  = 32'h400,
  parameter int unsigned     OFS_IRQ  = 32'h600,
  parameter logic [XLEN-1:0] RESET_PC = XLEN'(32'hA000_0000)
) (
  input  entry_kind_e       kind,
  input  logic [CODE_W-1:0] code,
  input  logic [SR_W-1:0]   sr_in,
  input  logic [XLEN-1:0]   pc_in,
  input  logic [XLEN-1:0]   vbr_in,
  input  logic              in_slot,
  output logic [SR_W-1:0]   sr_nxt,
  output logic [XLEN-1:0]   pc_nxt,
  output logic [XLEN-1:0]   spc_nxt
);
  localparam logic [CODE_W-1:0] C_PWR  = CODE_W'(12'h000);
  localparam logic [CODE_W-1:0] C_MAN  = CODE_W'(12'h020);
  localparam logic [CODE_W-1:0] C_MULT = CODE_W'(12'h140);
  localparam logic [CODE_W-1:0] C_TLBR = CODE_W'(12'h040);
  localparam logic [CODE_W-1:0] C_TLBW = CODE_W'(12'h060);
  localparam logic [CODE_W-1:0] C_TRAP = CODE_W'(12'h160);

  dest_class_e cls;
  logic [XLEN-1:0] spc_base;

  always_comb begin
    if (code == C_PWR || code == C_MAN || code == C_MULT) cls = DST_RESET;
    else if (code == C_TLBR || code == C_TLBW)            cls = DST_TLB;
    else                                                  cls = DST_GENERAL;
  end

  assign spc_base = pc_in - (in_slot ? XLEN'(2) : XLEN'(0));

  always_comb begin
    sr_nxt         = sr_in;
    sr_nxt[SR_BL]  = 1'b1;
    sr_nxt[SR_RB]  = 1'b1;
    sr_nxt[SR_MD]  = 1'b1;
    spc_nxt        = spc_base;
    pc_nxt         = vbr_in + XLEN'(OFS_IRQ);
    if (kind == ENT_EXC) begin
      unique case (cls)
        DST_RESET: begin
          sr_nxt[SR_FD] = 1'b0;
          sr_nxt[IMASK_LO +: IMASK_W] = '1;
          pc_nxt = RESET_PC;
        end
        DST_TLB: pc_nxt = vbr_in + XLEN'(OFS_TLB);
        default: begin
          pc_nxt = vbr_in + XLEN'(OFS_GEN);
          if (code == C_TRAP) spc_nxt = spc_base + XLEN'(2);
        end
      endcase
    end
  end
endmodule

// File: rtl/exsq_entry.sv
module exsq_entry
  import exsq_pkg::*;
#(
  parameter int              XLEN     = 32,
  parameter int              CODE_W   = 12,
  parameter int unsigned     OFS_GEN  = 32'h100,
  parameter int unsigned     OFS_TLB  = 32'h400,
  parameter int unsigned     OFS_IRQ  = 32'h600,
  parameter logic [XLEN-1:0] RESET_PC = XLEN'(32'hA000_0000)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_en,
  input  logic              exc_pend,
  input  logic [CODE_W-1:0] exc_code,
  input  logic              irq_req,
  input  logic              halted,
  output logic [3:0]        ic_mask,
  input  logic              ic_vld,
  input  logic [CODE_W-1:0] ic_vec,
  input  logic [31:0]       sr_in,
  input  logic [XLEN-1:0]   pc_in,
  input  logic [XLEN-1:0]   r15_in,
  input  logic [XLEN-1:0]   vbr_in,
  input  logic              ds_flag,
  input  logic              ds_cond_flag,
  output logic [31:0]       sr_o,
  output logic [31:0]       ssr_o,
  output logic [XLEN-1:0]   spc_o,
  output logic [XLEN-1:0]   sgr_o,
  output logic [XLEN-1:0]   pc_o,
  output logic [CODE_W-1:0] expevt_o,
  output logic [CODE_W-1:0] intevt_o,
  output logic              taken_o,
  output logic              ds_clr_o,
  output logic              halt_clr_o
);
  localparam logic [SR_W-1:0] SR_RST =
    (SR_W'(1) << SR_MD) | (SR_W'(1) << SR_BL) | (SR_W'(4'hF) << IMASK_LO);

  // reset: asserted asynchronously, released after two clock edges
  logic [1:0] rst_sync;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q_n = rst_sync[1];

  assign ic_mask = sr_in[IMASK_LO +: IMASK_W];

  entry_kind_e       kind;
  logic [CODE_W-1:0] code;
  logic              wake;
  logic [SR_W-1:0]   sr_ent;
  logic [XLEN-1:0]   pc_ent, spc_ent;
  logic              in_slot;
  logic              ld_en;

  assign in_slot = ds_flag | ds_cond_flag;

  exsq_arbiter #(.CODE_W(CODE_W)) u_arb (
    .exc_pend (exc_pend),
    .exc_code (exc_code),
    .irq_req  (irq_req),
    .halted   (halted),
    .blocked  (sr_in[SR_BL]),
    .ic_vld   (ic_vld),
    .kind     (kind),
    .code     (code),
    .wake     (wake)
  );

  exsq_target #(
    .XLEN(XLEN), .CODE_W(CODE_W), .OFS_GEN(OFS_GEN),
    .OFS_TLB(OFS_TLB), .OFS_IRQ(OFS_IRQ), .RESET_PC(RESET_PC)
  ) u_tgt (
    .kind    (kind),
    .code    (code),
    .sr_in   (sr_in),
    .pc_in   (pc_in),
    .vbr_in  (vbr_in),
    .in_slot (in_slot),
    .sr_nxt  (sr_ent),
    .pc_nxt  (pc_ent),
    .spc_nxt (spc_ent)
  );

  // next-state
  logic [31:0]       sr_d, ssr_d;
  logic [XLEN-1:0]   spc_d, sgr_d, pc_d;
  logic [CODE_W-1:0] expevt_d, intevt_d;
  logic              taken_d, ds_clr_d, halt_clr_d;

  assign ld_en = evt_en && (kind != ENT_NONE);

  always_comb begin
    sr_d       = sr_ent;
    ssr_d      = sr_in;
    spc_d      = spc_ent;
    sgr_d      = r15_in;
    pc_d       = pc_ent;
    expevt_d   = (kind == ENT_EXC) ? code : expevt_o;
    intevt_d   = (kind == ENT_IRQ) ? ic_vec : intevt_o;
    taken_d    = ld_en;
    ds_clr_d   = ld_en && in_slot;
    halt_clr_d = ld_en && wake;
  end

  // registers
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      sr_o     <= SR_RST;
      ssr_o    <= '0;
      spc_o    <= '0;
      sgr_o    <= '0;
      pc_o     <= RESET_PC;
      expevt_o <= '0;
      intevt_o <= '0;
    end else if (ld_en) begin
      sr_o     <= sr_d;
      ssr_o    <= ssr_d;
      spc_o    <= spc_d;
      sgr_o    <= sgr_d;
      pc_o     <= pc_d;
      expevt_o <= expevt_d;
      intevt_o <= intevt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      taken_o    <= 1'b0;
      ds_clr_o   <= 1'b0;
      halt_clr_o <= 1'b0;
    end else begin
      taken_o    <= taken_d;
      ds_clr_o   <= ds_clr_d;
      halt_clr_o <= halt_clr_d;
    end
  end
endmodule

// File: rtl/exsq_entry_chk.sv
module exsq_entry_chk #(
  parameter int          XLEN    = 32,
  parameter int          CODE_W  = 12,
  parameter int unsigned OFS_IRQ = 32'h600
) (
  input logic              clk,
  input logic              rst_n,
  input logic              evt_en,
  input logic              exc_pend,
  input logic [31:0]       sr_in,
  input logic [XLEN-1:0]   vbr_in,
  input logic              ds_flag,
  input logic              ds_cond_flag,
  input logic [31:0]       sr_o,
  input logic [31:0]       ssr_o,
  input logic [XLEN-1:0]   pc_o,
  input logic [CODE_W-1:0] intevt_o,
  input logic              taken_o,
  input logic              ds_clr_o
);
  a_r12_take_follows_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    taken_o |-> $past(evt_en));

  a_r12_pc_holds_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !taken_o |-> $stable(pc_o));

  a_r6_status_bits: assert property (@(posedge clk) disable iff (!rst_n)
    taken_o |-> (sr_o[28] && sr_o[29] && sr_o[30]));

  a_r6_saved_status: assert property (@(posedge clk) disable iff (!rst_n)
    taken_o |-> (ssr_o == $past(sr_in)));

  a_r2_intevt_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (taken_o && $past(exc_pend)) |-> $stable(intevt_o));

  a_r11_irq_vector: assert property (@(posedge clk) disable iff (!rst_n)
    (taken_o && !$past(exc_pend)) |-> (pc_o == $past(vbr_in) + XLEN'(OFS_IRQ)));

  a_r7_slot_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (taken_o && $past(ds_flag || ds_cond_flag)) |-> ds_clr_o);
endmodule

bind exsq_entry exsq_entry_chk #(
  .XLEN(XLEN), .CODE_W(CODE_W), .OFS_IRQ(OFS_IRQ)
) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_en(evt_en), .exc_pend(exc_pend),
  .sr_in(sr_in), .vbr_in(vbr_in), .ds_flag(ds_flag), .ds_cond_flag(ds_cond_flag),
  .sr_o(sr_o), .ssr_o(ssr_o), .pc_o(pc_o), .intevt_o(intevt_o),
  .taken_o(taken_o), .ds_clr_o(ds_clr_o)
);

// File: tb/exsq_entry_test.sv
`timescale 1ns/1ps
module exsq_entry_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        evt_en = 0, exc_pend = 0, irq_req = 0, halted = 0, ic_vld = 0;
  logic [11:0] exc_code = '0, ic_vec = '0;
  logic [31:0] sr_in = 32'h0000_8030, pc_in = 32'h0000_1000;
  logic [31:0] r15_in = 32'h0000_7FFC, vbr_in = 32'h8C00_0000;
  logic        ds_flag = 0, ds_cond_flag = 0;
  logic [3:0]  ic_mask;
  logic [31:0] sr_o, ssr_o, spc_o, sgr_o, pc_o;
  logic [11:0] expevt_o, intevt_o;
  logic        taken_o, ds_clr_o, halt_clr_o;

  int total = 0, bad = 0;
  bit done = 0, cmp_on = 0;

  always #2 clk = ~clk;

  exsq_entry uut (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  logic [31:0] m_sr, m_ssr, m_spc, m_sgr, m_pc;
  logic [11:0] m_exp, m_int;
  logic        m_tk, m_dc, m_hc;

  always @(posedge clk) begin : model
    logic [11:0] c;
    logic [31:0] s;
    bit go, ex, bl, slot;
    if (!rst_n) begin
      m_sr = 32'h5000_00F0; m_ssr = 0; m_spc = 0; m_sgr = 0; m_pc = 32'hA000_0000;
      m_exp = 0; m_int = 0; m_tk = 0; m_dc = 0; m_hc = 0;
    end else begin
      m_tk = 0; m_dc = 0; m_hc = 0;
      if (evt_en) begin
        bl = sr_in[28]; slot = ds_flag || ds_cond_flag;
        c = exc_code; go = 0; ex = 0;
        if (exc_pend) begin
          ex = 1; go = 1;
          if (bl && c != 12'h1E0) c = 12'h000;
        end else if (irq_req && ic_vld && (!bl || halted)) go = 1;
        if (go) begin
          m_ssr = sr_in; m_sgr = r15_in;
          s = slot ? pc_in - 2 : pc_in;
          m_sr = sr_in | 32'h7000_0000;
          m_tk = 1; m_dc = slot; m_hc = bl;
          if (!ex) begin
            m_int = ic_vec; m_pc = vbr_in + 32'h600;
          end else begin
            m_exp = c;
            case (c)
              12'h000, 12'h020, 12'h140: begin
                m_sr[15] = 0; m_sr[7:4] = 4'hF; m_pc = 32'hA000_0000;
              end
              12'h040, 12'h060: m_pc = vbr_in + 32'h400;
              default: begin
                if (c == 12'h160) s = s + 2;
                m_pc = vbr_in + 32'h100;
              end
            endcase
          end
          m_spc = s;
        end
      end
    end
  end

  // per-cycle comparison, away from the edge (R12)
  always @(posedge clk) begin
    #1;
    if (cmp_on) begin
      chk("R12 cyc sr", sr_o, m_sr);
      chk("R12 cyc ssr", ssr_o, m_ssr);
      chk("R12 cyc spc", spc_o, m_spc);
      chk("R12 cyc sgr", sgr_o, m_sgr);
      chk("R12 cyc pc", pc_o, m_pc);
      chk("R12 cyc expevt", {20'd0, expevt_o}, {20'd0, m_exp});
      chk("R12 cyc intevt", {20'd0, intevt_o}, {20'd0, m_int});
      chk("R12 cyc pulses", {29'd0, taken_o, ds_clr_o, halt_clr_o}, {29'd0, m_tk, m_dc, m_hc});
    end
  end

  task automatic fire(input bit ep, input logic [11:0] ec, input bit ir, input bit vld,
                      input logic [11:0] vec, input bit hl, input logic [31:0] sr,
                      input bit dsf, input bit dsc, input bit strobe);
    @(negedge clk);
    exc_pend = ep; exc_code = ec; irq_req = ir; ic_vld = vld; ic_vec = vec;
    halted = hl; sr_in = sr; ds_flag = dsf; ds_cond_flag = dsc; evt_en = strobe;
    @(negedge clk);
    evt_en = 0; exc_pend = 0; irq_req = 0; ic_vld = 0; halted = 0;
    ds_flag = 0; ds_cond_flag = 0;
  endtask

  initial begin
    #300000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  localparam logic [31:0] U = 32'h0000_8030;
  localparam logic [31:0] B = 32'h1000_8030;

  initial begin
    #1 rst_n = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    cmp_on = 1;
    repeat (4) @(negedge clk);
    // R1
    chk("R1 pc", pc_o, 32'hA000_0000);
    chk("R1 sr", sr_o, 32'h5000_00F0);
    chk("R1 spc", spc_o, 0);
    chk("R1 pulses", {29'd0, taken_o, ds_clr_o, halt_clr_o}, 0);
    // R5 mask
    sr_in = U; #1;
    chk("R5 mask", {28'd0, ic_mask}, 32'h3);
    sr_in = 32'h0000_00A0; #1;
    chk("R5 mask2", {28'd0, ic_mask}, 32'hA);
    // R6 + R10 general
    fire(1, 12'h180, 0, 0, 0, 0, U, 0, 0, 1);
    chk("R6 taken", {31'd0, taken_o}, 1);
    chk("R6 ssr", ssr_o, U);
    chk("R6 spc", spc_o, 32'h1000);
    chk("R6 sgr", sgr_o, 32'h7FFC);
    chk("R6 sr", sr_o, 32'h7000_8030);
    chk("R10 pc", pc_o, 32'h8C00_0100);
    chk("R10 expevt", {20'd0, expevt_o}, 32'h180);
    // R10 trapa
    fire(1, 12'h160, 0, 0, 0, 0, U, 0, 0, 1);
    chk("R10 trapa spc", spc_o, 32'h1002);
    chk("R10 trapa pc", pc_o, 32'h8C00_0100);
    // R9
    fire(1, 12'h040, 0, 0, 0, 0, U, 0, 0, 1);
    chk("R9 tlb read pc", pc_o, 32'h8C00_0400);
    fire(1, 12'h060, 0, 0, 0, 0, U, 0, 0, 1);
    chk("R9 tlb write pc", pc_o, 32'h8C00_0400);
    // R8
    fire(1, 12'h140, 0, 0, 0, 0, U, 0, 0, 1);
    chk("R8 sr", sr_o, 32'h7000_00F0);
    chk("R8 pc", pc_o, 32'hA000_0000);
    fire(1, 12'h020, 0, 0, 0, 0, U, 0, 0, 1);
    chk("R8 manual pc", pc_o, 32'hA000_0000);
    // R11
    fire(0, 0, 1, 1, 12'h320, 0, U, 0, 0, 1);
    chk("R11 intevt", {20'd0, intevt_o}, 32'h320);
    chk("R11 pc", pc_o, 32'h8C00_0600);
    chk("R11 expevt kept", {20'd0, expevt_o}, 32'h020);
    // R2
    fire(1, 12'h0E0, 1, 1, 12'h200, 0, U, 0, 0, 1);
    chk("R2 expevt", {20'd0, expevt_o}, 32'h0E0);
    chk("R2 intevt", {20'd0, intevt_o}, 32'h320);
    chk("R2 pc", pc_o, 32'h8C00_0100);
    // R5 no vector
    fire(0, 0, 1, 0, 12'h240, 0, U, 0, 0, 1);
    chk("R5 not taken", {31'd0, taken_o}, 0);
    chk("R5 pc held", pc_o, 32'h8C00_0100);
    // R3
    fire(1, 12'h0A0, 0, 0, 0, 0, B, 0, 0, 1);
    chk("R3 expevt", {20'd0, expevt_o}, 0);
    chk("R3 pc", pc_o, 32'hA000_0000);
    chk("R3 sr", sr_o, 32'h7000_00F0);
    chk("R4 halt_clr on blocked take", {31'd0, halt_clr_o}, 1);
    fire(1, 12'h1E0, 0, 0, 0, 0, B, 0, 0, 1);
    chk("R3 keep code", {20'd0, expevt_o}, 32'h1E0);
    chk("R3 keep pc", pc_o, 32'h8C00_0100);
    // R4
    fire(0, 0, 1, 1, 12'h400, 0, B, 0, 0, 1);
    chk("R4 held off", {31'd0, taken_o}, 0);
    chk("R4 pc held", pc_o, 32'h8C00_0100);
    chk("R4 intevt held", {20'd0, intevt_o}, 32'h320);
    fire(0, 0, 1, 1, 12'h400, 1, B, 0, 0, 1);
    chk("R4 halted taken", {31'd0, taken_o}, 1);
    chk("R4 halt_clr", {31'd0, halt_clr_o}, 1);
    chk("R4 intevt", {20'd0, intevt_o}, 32'h400);
    // R7
    fire(1, 12'h180, 0, 0, 0, 0, U, 1, 0, 1);
    chk("R7 spc", spc_o, 32'h0FFE);
    chk("R7 ds_clr", {31'd0, ds_clr_o}, 1);
    fire(1, 12'h160, 0, 0, 0, 0, U, 0, 1, 1);
    chk("R7 cond trapa spc", spc_o, 32'h1000);
    chk("R7 cond ds_clr", {31'd0, ds_clr_o}, 1);
    // R12 no strobe
    fire(1, 12'h040, 1, 1, 12'h100, 0, U, 0, 0, 0);
    chk("R12 no strobe taken", {31'd0, taken_o}, 0);
    chk("R12 no strobe pc", pc_o, 32'h8C00_0100);
    repeat (3) @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule